// File: doc/BRIEF.md
# Pattern Generator and Bit Error Tester

This block sits on a serial TDM data path and measures its error performance. The transmit side emits a test stream: one of two maximal-length pseudo-random sequences or a user pattern of 1 to 32 bits that repeats. The stream can be corrupted on purpose, either one bit on a command pulse or one bit in every 10^n bits at a chosen decade rate. Each bit advances only on a bit-rate clock enable.

The receive side predicts each incoming bit from the bits it has already seen. It declares lock after a run of clean predictions. While locked it counts the bits it checks and the bits that differ, and it drops lock when errors cluster. A latch pulse moves both counts into holding outputs and restarts counting, so software can form the error ratio from the two held values.

Top module: `bert_top`

## Requirements
- R1: With modeSel = 0 the transmit LFSR starts from all ones, so the first 15 transmitted bits after reset are 1. Every later bit follows b[k+15] = b[k] xor b[k+1].
- R2: With modeSel = 1 the first 23 transmitted bits after reset are 1, and b[k+23] = b[k] xor b[k+5].
- R3: With modeSel = 2 or 3 and patLen = L-1, transmitted bit k after reset is patWord[k mod L]. Bit 0 of patWord goes out first.
- R4: txData and inSync change only in cycles where bitEn is high.
- R5: The receiver predicts each bit from its received history: in the two PRBS modes with the same recurrence as R1 and R2, and in pattern mode as the bit L positions earlier. After 32 consecutive correctly predicted bits it raises inSync. After reset it locks to a clean looped-back stream within 80 bits, and never before 32 bits.
- R6: While inSync is high, each bit increments the bit count and each mispredicted bit increments the error count. The error count never exceeds the bit count.
- R7: A one-cycle pulse on injOne inverts exactly the next transmitted bit.
- R8: While rateEn is high, every 10^n-th transmitted bit is inverted, with n = rateExp in the range 1 to 7. A rateExp of 0 acts as 1.
- R9: Lock is kept through fewer than 6 errors in a 64-bit window. The windows are counted from the moment of lock. A sixth error within one window clears inSync.
- R10: Both counts saturate at all ones and do not wrap.
- R11: A latchCmd pulse copies the bit and error counts to bitHold and errHold and restarts both counts. A bit checked in that same cycle counts as the first bit of the new interval. The holds change only on latchCmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-rate enable, one pulse per bit |
| modeSel | input | 2 | 0: PRBS 2^15-1, 1: PRBS 2^23-1, 2/3: repeating pattern |
| patWord | input | PAT_W | Repeating pattern, bit 0 sent first |
| patLen | input | LEN_W | Pattern length minus one |
| rxData | input | 1 | Serial data under test |
| injOne | input | 1 | Invert the next transmitted bit |
| rateEn | input | 1 | Enable decade-rate error insertion |
| rateExp | input | 3 | Decade exponent n for one error per 10^n bits |
| latchCmd | input | 1 | Copy the counts to the holds and restart them |
| txData | output | 1 | Serial test stream |
| inSync | output | 1 | Receiver locked |
| bitHold | output | CNT_W | Held bit count |
| errHold | output | CNT_W | Held error count |

## Verification
A wrong tap or seed in a transmit LFSR shows on txData within 15 or 23 bits of reset, because the stream breaks the recurrence. A fault in the receive history or its prediction shows as a lock that never comes, or as errors in the held counts after the next latch. A wrong window count or error threshold shows as inSync staying high through a 12-bit error burst, or falling after five scattered errors. A faulty counter shows in bitHold or errHold at the next latch pulse.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam logic [1:0] MODE_P15 = 2'd0;
  localparam logic [1:0] MODE_P23 = 2'd1;

  typedef struct packed {
    logic step;   // one bit time elapses
    logic track;  // receiver locked: history follows predictions
    logic count;  // bit is counted
    logic latch;  // move counts to holds
    logic flip;   // invert the bit being transmitted
  } bertStrobe_t;
endpackage

// File: rtl/bert_ctrl.sv
module bert_ctrl import bert_pkg::*; #(
  parameter int SYNC_BITS = 32,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        injOne,
  input  logic        rateEn,
  input  logic [2:0]  rateExp,
  input  logic        latchCmd,
  input  logic        mismatch,
  output bertStrobe_t strobe,
  output logic        inSync
);
  localparam int RUN_W  = $clog2(SYNC_BITS + 1);
  localparam int WIN_W  = $clog2(WIN_BITS + 1);
  localparam int ERR_W  = $clog2(LOSS_ERRS + 1);
  localparam int RATE_W = 24;

  logic              syncQ;
  logic [RUN_W-1:0]  runCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [ERR_W-1:0]  winErr, winErrNext;
  logic              pend;
  logic [RATE_W-1:0] rateCnt, rateLimit;
  logic              rateHit;

  always_comb begin
    case (rateExp)
      3'd2:    rateLimit = RATE_W'(99);
      3'd3:    rateLimit = RATE_W'(999);
      3'd4:    rateLimit = RATE_W'(9999);
      3'd5:    rateLimit = RATE_W'(99999);
      3'd6:    rateLimit = RATE_W'(999999);
      3'd7:    rateLimit = RATE_W'(9999999);
      default: rateLimit = RATE_W'(9);
    endcase
  end

  assign rateHit    = rateEn && (rateCnt == rateLimit);
  assign winErrNext = winErr + ERR_W'(mismatch);

  always_comb begin
    strobe.step  = bitEn;
    strobe.track = syncQ;
    strobe.count = bitEn && syncQ;
    strobe.latch = latchCmd;
    strobe.flip  = bitEn && (pend || injOne || rateHit);
  end

  assign inSync = syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= 1'b0;
      rateCnt <= '0;
    end else begin
      pend <= (pend || injOne) && !bitEn;
      if (!rateEn)    rateCnt <= '0;
      else if (bitEn) rateCnt <= rateHit ? '0 : rateCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 1'b0;
      runCnt <= '0;
      winCnt <= '0;
      winErr <= '0;
    end else if (bitEn) begin
      if (!syncQ) begin
        if (mismatch) begin
          runCnt <= '0;
        end else if (runCnt == RUN_W'(SYNC_BITS - 1)) begin
          syncQ  <= 1'b1;
          runCnt <= '0;
          winCnt <= '0;
          winErr <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        if (winErrNext >= ERR_W'(LOSS_ERRS)) begin
          syncQ  <= 1'b0;
          runCnt <= '0;
        end else if (winCnt == WIN_W'(WIN_BITS - 1)) begin
          winCnt <= '0;
          winErr <= '0;
        end else begin
          winCnt <= winCnt + 1'b1;
          winErr <= winErrNext;
        end
      end
    end
  end
endmodule

// File: rtl/bert_datapath.sv
module bert_datapath import bert_pkg::*; #(
  parameter int PAT_W = 32,
  parameter int CNT_W = 32,
  parameter int LEN_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bertStrobe_t      strobe,
  input  logic [1:0]       modeSel,
  input  logic [PAT_W-1:0] patWord,
  input  logic [LEN_W-1:0] patLen,
  input  logic             rxData,
  output logic             txData,
  output logic             mismatch,
  output logic [CNT_W-1:0] bitCnt,
  output logic [CNT_W-1:0] errCnt,
  output logic [CNT_W-1:0] bitHold,
  output logic [CNT_W-1:0] errHold
);
  localparam int HIST_W = (PAT_W > 23) ? PAT_W : 23;

  logic [14:0]       lfsr15;
  logic [22:0]       lfsr23;
  logic [LEN_W-1:0]  pos;
  logic [HIST_W-1:0] hist;
  logic              genBit, expBit;

  always_comb begin
    case (modeSel)
      MODE_P15: begin genBit = lfsr15[14]; expBit = hist[14] ^ hist[13]; end
      MODE_P23: begin genBit = lfsr23[22]; expBit = hist[22] ^ hist[17]; end
      default:  begin genBit = patWord[pos]; expBit = hist[patLen]; end
    endcase
  end

  assign mismatch = rxData ^ expBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr15 <= '1;
      lfsr23 <= '1;
      pos    <= '0;
      txData <= 1'b0;
      hist   <= '0;
    end else if (strobe.step) begin
      lfsr15 <= {lfsr15[13:0], lfsr15[14] ^ lfsr15[13]};
      lfsr23 <= {lfsr23[21:0], lfsr23[22] ^ lfsr23[17]};
      pos    <= (pos == patLen) ? '0 : pos + 1'b1;
      txData <= genBit ^ strobe.flip;
      hist   <= {hist[HIST_W-2:0], strobe.track ? expBit : rxData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      errCnt  <= '0;
      bitHold <= '0;
      errHold <= '0;
    end else if (strobe.latch) begin
      bitHold <= bitCnt;
      errHold <= errCnt;
      bitCnt  <= CNT_W'(strobe.count);
      errCnt  <= CNT_W'(strobe.count && mismatch);
    end else if (strobe.count) begin
      if (!(&bitCnt))             bitCnt <= bitCnt + 1'b1;
      if (mismatch && !(&errCnt)) errCnt <= errCnt + 1'b1;
    end
  end
endmodule

// File: rtl/bert_top.sv
module bert_top import bert_pkg::*; #(
  parameter int PAT_W     = 32,
  parameter int CNT_W     = 32,
  parameter int SYNC_BITS = 32,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6,
  parameter int LEN_W     = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [1:0]       modeSel,
  input  logic [PAT_W-1:0] patWord,
  input  logic [LEN_W-1:0] patLen,
  input  logic             rxData,
  input  logic             injOne,
  input  logic             rateEn,
  input  logic [2:0]       rateExp,
  input  logic             latchCmd,
  output logic             txData,
  output logic             inSync,
  output logic [CNT_W-1:0] bitHold,
  output logic [CNT_W-1:0] errHold
);
  bertStrobe_t      strobe;
  logic             mismatch;
  logic [CNT_W-1:0] bitCnt, errCnt;

  bert_ctrl #(
    .SYNC_BITS(SYNC_BITS), .WIN_BITS(WIN_BITS), .LOSS_ERRS(LOSS_ERRS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .injOne(injOne),
    .rateEn(rateEn), .rateExp(rateExp), .latchCmd(latchCmd),
    .mismatch(mismatch), .strobe(strobe), .inSync(inSync)
  );

  bert_datapath #(
    .PAT_W(PAT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .patWord(patWord), .patLen(patLen), .rxData(rxData),
    .txData(txData), .mismatch(mismatch), .bitCnt(bitCnt),
    .errCnt(errCnt), .bitHold(bitHold), .errHold(errHold)
  );
endmodule

// File: rtl/bert_chk.sv
module bert_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             latchCmd,
  input logic             txData,
  input logic             inSync,
  input logic [CNT_W-1:0] bitCnt,
  input logic [CNT_W-1:0] errCnt,
  input logic [CNT_W-1:0] bitHold,
  input logic [CNT_W-1:0] errHold
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_TX_ONLY_ON_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txData)); // R4
  AST_SYNC_ONLY_ON_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(inSync)); // R4
  AST_ERR_NOT_ABOVE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= bitCnt); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !latchCmd |=> (bitCnt == $past(bitCnt)) || (bitCnt == $past(bitCnt) + ONE)); // R6
  AST_BIT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (!latchCmd && (&bitCnt)) |=> (&bitCnt)); // R10
  AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (!latchCmd && (&errCnt)) |=> (&errCnt)); // R10
  AST_HOLD_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !latchCmd |=> $stable(bitHold) && $stable(errHold)); // R11
  AST_LATCH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    latchCmd |=> (bitCnt <= ONE) && (errCnt <= ONE)); // R11
endmodule

bind bert_top bert_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .latchCmd(latchCmd),
  .txData(txData), .inSync(inSync), .bitCnt(bitCnt), .errCnt(errCnt),
  .bitHold(bitHold), .errHold(errHold)
);

// File: tb/test_bert_top.sv
module test_bert_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NLOG = 2000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitEn = 1'b0;
  logic [1:0]    modeSel = 2'd0;
  logic [31:0]   patWord = '0;
  logic [4:0]    patLen = '0;
  logic          rxData;
  logic          injOne = 1'b0;
  logic          rateEn = 1'b0;
  logic [2:0]    rateExp = 3'd1;
  logic          latchCmd = 1'b0;
  logic          txData, inSync;
  logic [CW-1:0] bitHold, errHold;
  logic          flipRx = 1'b0;

  int  total = 0;
  int  bad = 0;
  int  unstable = 0;
  bit  finished = 0;
  bit  txLog [NLOG];

  assign rxData = txData ^ flipRx;

  bert_top #(.CNT_W(CW)) i_bert_top (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeSel(modeSel),
    .patWord(patWord), .patLen(patLen), .rxData(rxData), .injOne(injOne),
    .rateEn(rateEn), .rateExp(rateExp), .latchCmd(latchCmd),
    .txData(txData), .inSync(inSync), .bitHold(bitHold), .errHold(errHold)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bit time: enable cycle, then an idle cycle in which txData must hold
  task automatic oneBit();
    logic prev;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    prev = txData;
    @(negedge clk);
    if (txData !== prev) unstable++;
  endtask

  task automatic runBits(input int n);
    for (int i = 0; i < n; i++) oneBit();
  endtask

  task automatic doLatch();
    latchCmd = 1'b1;
    @(negedge clk);
    latchCmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] m, input logic [4:0] len, input logic [31:0] w);
    rstN = 1'b0;
    modeSel = m;
    patLen = len;
    patWord = w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int syncAt;
    int errs;
    @(negedge clk);

    // reset state
    doReset(2'd0, 5'd0, 32'h0);
    chk(txData == 1'b0 && inSync == 1'b0, "R4 reset outputs", {txData, inSync}, 0);
    chk(bitHold == 0 && errHold == 0, "R11 reset holds", bitHold + errHold, 0);

    // R1: PRBS 2^15-1 sequence, and lock time per R5
    syncAt = -1;
    for (int k = 0; k < NLOG; k++) begin
      oneBit();
      txLog[k] = txData;
      if (inSync && syncAt < 0) syncAt = k + 1;
    end
    errs = 0;
    for (int k = 0; k < 15; k++) if (!txLog[k]) errs++;
    chk(errs == 0, "R1 seed ones", errs, 0);
    errs = 0;
    for (int k = 0; k + 15 < NLOG; k++)
      if (txLog[k+15] != (txLog[k] ^ txLog[k+1])) errs++;
    chk(errs == 0, "R1 recurrence", errs, 0);
    chk(syncAt >= 32 && syncAt <= 80, "R5 lock time prbs15", syncAt, 32);

    // R6: clean counting
    doLatch();
    runBits(300);
    doLatch();
    chk(bitHold == 300, "R6 bit count", bitHold, 300);
    chk(errHold == 0, "R6 error count clean", errHold, 0);

    // R7: single inserted error
    injOne = 1'b1;
    @(negedge clk);
    injOne = 1'b0;
    runBits(50);
    doLatch();
    chk(errHold == 1, "R7 single error", errHold, 1);
    chk(bitHold == 50, "R7 bit count", bitHold, 50);

    // R9: five scattered errors keep lock
    for (int i = 0; i < 100; i++) begin
      flipRx = (i % 3 == 0) && (i < 15);
      oneBit();
    end
    flipRx = 1'b0;
    doLatch();
    chk(errHold == 5, "R9 five errors counted", errHold, 5);
    chk(inSync == 1'b1, "R9 lock kept", inSync, 1);

    // R9: twelve-bit burst drops lock, R5 lock regained
    for (int i = 0; i < 12; i++) begin
      flipRx = 1'b1;
      oneBit();
    end
    flipRx = 1'b0;
    chk(inSync == 1'b0, "R9 lock lost", inSync, 0);
    runBits(100);
    chk(inSync == 1'b1, "R5 relock", inSync, 1);

    // R8: one error per 100 bits
    doLatch();
    rateExp = 3'd2;
    rateEn = 1'b1;
    runBits(1005);
    rateEn = 1'b0;
    doLatch();
    chk(errHold == 10, "R8 decade rate errors", errHold, 10);
    chk(bitHold == 1005, "R8 decade rate bits", bitHold, 1005);

    // R8: exponent 0 acts as 1 (one per 10), which exceeds the R9 limit
    rateExp = 3'd0;
    rateEn = 1'b1;
    runBits(200);
    chk(inSync == 1'b0, "R8 rate 1/10 drops lock", inSync, 0);
    rateEn = 1'b0;
    runBits(100);
    chk(inSync == 1'b1, "R5 relock after rate", inSync, 1);

    // R10: saturation of the bit count
    doLatch();
    runBits(4200);
    doLatch();
    chk(bitHold == 4095, "R10 saturation", bitHold, 4095);
    chk(errHold == 0, "R10 errors", errHold, 0);

    // R11: back-to-back latch holds a restarted count
    doLatch();
    chk(bitHold == 0 && errHold == 0, "R11 restart", bitHold, 0);

    // R2: PRBS 2^23-1
    doReset(2'd1, 5'd0, 32'h0);
    syncAt = -1;
    for (int k = 0; k < NLOG; k++) begin
      oneBit();
      txLog[k] = txData;
      if (inSync && syncAt < 0) syncAt = k + 1;
    end
    errs = 0;
    for (int k = 0; k < 23; k++) if (!txLog[k]) errs++;
    chk(errs == 0, "R2 seed ones", errs, 0);
    errs = 0;
    for (int k = 0; k + 23 < NLOG; k++)
      if (txLog[k+23] != (txLog[k] ^ txLog[k+5])) errs++;
    chk(errs == 0, "R2 recurrence", errs, 0);
    chk(syncAt >= 32 && syncAt <= 80, "R5 lock time prbs23", syncAt, 32);

    // R3: every pattern length 1..32
    for (int len = 1; len <= 32; len++) begin
      logic [31:0] w;
      w = 32'hB5C3_96E1 ^ (32'h0F0F_3C3C << (len % 7));
      doReset(2'd2, 5'(len - 1), w);
      errs = 0;
      for (int k = 0; k < 110; k++) begin
        oneBit();
        if (txData != w[k % len]) errs++;
      end
      chk(errs == 0, $sformatf("R3 pattern len %0d", len), errs, 0);
      chk(inSync == 1'b1, $sformatf("R5 pattern lock len %0d", len), inSync, 1);
    end

    // R7 in pattern mode
    doReset(2'd3, 5'd6, 32'h0000_0035);
    runBits(80);
    doLatch();
    injOne = 1'b1;
    @(negedge clk);
    injOne = 1'b0;
    runBits(40);
    doLatch();
    chk(errHold == 1, "R7 pattern mode error", errHold, 1);

    chk(unstable == 0, "R4 txData stable between bits", unstable, 0);
    summary();
  end
endmodule